// File: doc/BRIEF.md
# Buffered Serial Transmitter with Break Insertion

This block sends bytes on an asynchronous serial line. One holding register sits in front of the shift register, so software can load the next byte while the current frame is still on the wire. A free-running tick input sets the bit rate, and the block needs a fixed number of ticks for each bit. Software reads two status flags, holding-register empty and transmission complete, and each flag can raise an interrupt request through its own enable bit.

The control inputs cover the rest of the line behaviour. Setting the enable sends one all-ones idle frame before any other frame. Holding the break bit sends whole all-zero frames, followed by one mark bit so that a receiver can see the next start bit. Clearing the enable lets every frame that is in progress or owed finish, and discards any byte still waiting in the holding register. A mode input selects between push-pull drive and an open-drain style, in which the drive enable is raised only to pull the line low, so that several transmitters can share one wired-OR line.

Top module: `ser_tx_dbuf`

## Requirements
- R1: A data frame is a 0 start bit, then the eight data bits least significant first, then a 1 stop bit. Each bit lasts TPB tick pulses, and clock cycles without a tick do not advance the frame.
- R2: A write clears `empty` in the following cycle. A write while `empty` is low replaces the waiting byte. When the shifter is free and the transmitter is enabled, the waiting byte moves into the shifter and `empty` rises on the next clock, so a write to an idle transmitter shows `empty` low for exactly one cycle.
- R3: `done` is low whenever a frame is being shifted and rises when the shifter stops with nothing owed. While the shifter is idle, `done` clears only on a write that follows a status read (`rd` high) made while `done` was set. A write without such a read leaves it set.
- R4: A rising edge on `en` causes one idle frame of ten mark bits to be sent. If a frame is in progress, the idle frame follows it directly. When the idle frame starts from an idle shifter, `done` falls on the clock at which `en` is first seen high.
- R5: A break request (`brk` high while `en` is high) causes all-zero frames of frame length. At least one is sent, even for a one-cycle request. A frame already on the line finishes first, and a break outranks a waiting data byte. The break stops at the end of the break frame during which `brk` drops.
- R6: After the last break frame, the line is held at mark for exactly one bit time before the next frame begins.
- R7: When `en` is low, the holding register is flushed (`empty` high) and writes are discarded. Frames already started or owed still complete. After that, `txd` is 1 and `txd_oe` is 0.
- R8: While enabled with nothing to send, the line rests at mark with `empty` and `done` both high.
- R9: With `od` high, `txd_oe` is high only while the line is driven low. With `od` low, `txd_oe` is high whenever the transmitter is active.
- R10: `irq_empty` follows `empty` while `ie_empty` is high, and `irq_done` follows `done` while `ie_done` is high. Each request is 0 when its enable is low.
- R11: After reset the shifter is idle, `empty` and `done` are 1, `txd` is 1 and `txd_oe` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Bit-rate tick, one pulse per sub-bit period |
| en | input | 1 | Transmitter enable |
| brk | input | 1 | Break request |
| od | input | 1 | Open-drain mode select |
| ie_empty | input | 1 | Interrupt enable for holding-register empty |
| ie_done | input | 1 | Interrupt enable for transmission complete |
| wr | input | 1 | Data register write strobe |
| wdata | input | DW | Byte to send |
| rd | input | 1 | Status register read strobe |
| txd | output | 1 | Serial line level |
| txd_oe | output | 1 | Line drive enable |
| empty | output | 1 | Holding register empty flag |
| done | output | 1 | Transmission complete flag |
| irq_empty | output | 1 | Holding-register empty interrupt request |
| irq_done | output | 1 | Transmission complete interrupt request |

## Verification
The checker watches four invariants on every cycle. An `empty` flag never falls without a write. The line is always at mark while `done` is set. In open-drain mode the drive enable never coincides with a high line, and after a shutdown the outputs stay released. It also checks that a rising enable on an idle transmitter immediately starts the idle frame. The bench scenarios cover what needs whole frames to show: bit order and tick pacing over every byte value, overwrite of a waiting byte, exact break and mark lengths measured as line run lengths, the idle frame inserted after a busy frame, the read-then-write clearing order, and the discarding of a byte on disable.

// File: rtl/ser_tx_dbuf.sv
module ser_tx_dbuf #(
  parameter int TPB = 16,
  parameter int DW  = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          en,
  input  logic          brk,
  input  logic          od,
  input  logic          ie_empty,
  input  logic          ie_done,
  input  logic          wr,
  input  logic [DW-1:0] wdata,
  input  logic          rd,
  output logic          txd,
  output logic          txd_oe,
  output logic          empty,
  output logic          done,
  output logic          irq_empty,
  output logic          irq_done
);

  localparam int FL = DW + 2;
  localparam int TW = (TPB > 1) ? $clog2(TPB) : 1;
  localparam int BW = $clog2(FL + 1);

  typedef enum logic [2:0] {K_NONE, K_IDLE, K_BRK, K_DATA, K_MARK} kind_t;

  logic [DW-1:0] hold;
  logic [FL-1:0] sh;
  logic [TW-1:0] tcnt;
  logic [BW-1:0] left;
  logic          busy, in_brk, brk_pend, pre_pend, en_q, armed;
  kind_t         nk;

  wire pre_req = pre_pend | (en & ~en_q);
  wire bit_end = busy & tick & (tcnt == TW'(TPB - 1));
  wire fin     = bit_end & (left == BW'(1));
  wire ld      = (~busy | fin) & (nk != K_NONE);
  wire ld_bm   = ld & ((nk == K_BRK) | (nk == K_MARK));

  always_comb begin
    if (fin & in_brk)       nk = (brk & en) ? K_BRK : K_MARK;
    else if (pre_req)       nk = K_IDLE;
    else if (brk_pend)      nk = K_BRK;
    else if (en & ~empty)   nk = K_DATA;
    else                    nk = K_NONE;
  end

  logic done_n;
  always_comb begin
    done_n = done;
    if (ld)              done_n = 1'b0;
    else if (fin)        done_n = 1'b1;
    else if (wr & armed) done_n = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold     <= '0;
      sh       <= '1;
      tcnt     <= '0;
      left     <= '0;
      busy     <= 1'b0;
      in_brk   <= 1'b0;
      brk_pend <= 1'b0;
      pre_pend <= 1'b0;
      en_q     <= 1'b0;
      armed    <= 1'b0;
      empty    <= 1'b1;
      done     <= 1'b1;
    end else begin
      en_q     <= en;
      pre_pend <= pre_req & ~(ld & (nk == K_IDLE));
      brk_pend <= en & ~ld_bm & (brk_pend | (brk & ~(busy & in_brk)));
      done     <= done_n;
      armed    <= done_n & ~wr & (armed | (rd & done));
      if (wr) hold <= wdata;
      if (~en)                      empty <= 1'b1;
      else if (wr)                  empty <= 1'b0;
      else if (ld & (nk == K_DATA)) empty <= 1'b1;

      if (ld) begin
        busy   <= 1'b1;
        tcnt   <= '0;
        in_brk <= (nk == K_BRK);
        left   <= (nk == K_MARK) ? BW'(1) : BW'(FL);
        case (nk)
          K_BRK:   sh <= '0;
          K_DATA:  sh <= {1'b1, hold, 1'b0};
          default: sh <= '1;
        endcase
      end else if (fin) begin
        busy   <= 1'b0;
        in_brk <= 1'b0;
      end else if (bit_end) begin
        tcnt <= '0;
        sh   <= {1'b1, sh[FL-1:1]};
        left <= left - 1'b1;
      end else if (busy & tick) begin
        tcnt <= tcnt + 1'b1;
      end
    end
  end

  wire line = ~busy | sh[0];
  wire act  = en | busy;

  assign txd       = ~act | line;
  assign txd_oe    = act & (~od | ~line);
  assign irq_empty = ie_empty & empty;
  assign irq_done  = ie_done & done;

endmodule

module ser_tx_dbuf_chk (
  input logic clk,
  input logic rst_n,
  input logic en,
  input logic od,
  input logic wr,
  input logic txd,
  input logic txd_oe,
  input logic empty,
  input logic done
);

  // R2
  empty_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(empty) |-> $past(wr));

  // R3
  done_mark_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> txd);

  // R4
  preamble_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(en) && done) |=> !done);

  // R9
  od_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (od && txd_oe) |-> !txd);

  // R7
  released_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && done) |-> (!txd_oe && txd));

endmodule

bind ser_tx_dbuf ser_tx_dbuf_chk i_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .od(od), .wr(wr),
  .txd(txd), .txd_oe(txd_oe), .empty(empty), .done(done)
);

// File: tb/test_ser_tx_dbuf.sv
`timescale 1ns/1ps
module test_ser_tx_dbuf;
  localparam int TPB = 4;

  logic clk = 0, rst_n = 0, tick, en = 0, brk = 0, od = 0;
  logic ie_empty = 1, ie_done = 1, wr = 0, rd = 0;
  logic [7:0] wdata = 0;
  logic txd, txd_oe, empty, done, irq_empty, irq_done;

  always #2.5 clk = ~clk;

  int div = 1, tc = 0, bitc = TPB;
  always @(posedge clk) tc <= (tc + 1 >= div) ? 0 : tc + 1;
  assign tick = (tc == 0);

  ser_tx_dbuf #(.TPB(TPB), .DW(8)) i_ser_tx_dbuf (
    .clk(clk), .rst_n(rst_n), .tick(tick), .en(en), .brk(brk), .od(od),
    .ie_empty(ie_empty), .ie_done(ie_done), .wr(wr), .wdata(wdata), .rd(rd),
    .txd(txd), .txd_oe(txd_oe), .empty(empty), .done(done),
    .irq_empty(irq_empty), .irq_done(irq_done));

  int n_chk = 0, n_fail = 0;
  task automatic chk(input bit c, input string r, input int a, input int e);
    n_chk++;
    if (!c) begin n_fail++; $display("FAIL %s: got %0d expected %0d", r, a, e); end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  // frame decoder: pushes byte value, or -1 for a zero-stop (break) frame
  int rx[0:399];
  int rx_n = 0;
  bit prevb = 1;
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && txd === 1'b0 && prevb) begin
        int v;
        v = 0;
        repeat (bitc / 2) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
          repeat (bitc) @(negedge clk);
          if (txd) v = v | (1 << i);
        end
        repeat (bitc) @(negedge clk);
        if (txd) begin
          if (rx_n < 400) rx[rx_n] = v;
          rx_n++;
        end else begin
          if (rx_n < 400) rx[rx_n] = -1;
          rx_n++;
          while (txd !== 1'b1) @(negedge clk);
        end
        prevb = (txd === 1'b1);
      end else prevb = (txd === 1'b1);
    end
  end

  // run-length recorder of the line
  int rl_lvl[0:63];
  int rl_len[0:63];
  int rl_n = 0, cur_len = 0;
  logic cur_lvl = 1;
  bit rq_clear = 0;
  always @(negedge clk) begin
    if (rq_clear) begin
      rq_clear = 0; rl_n = 0; cur_lvl = txd; cur_len = 1;
    end else if (txd === cur_lvl) cur_len++;
    else begin
      if (rl_n < 64) begin rl_lvl[rl_n] = cur_lvl; rl_len[rl_n] = cur_len; end
      rl_n++; cur_lvl = txd; cur_len = 1;
    end
  end
  task automatic rclr();
    @(posedge clk); rq_clear = 1;
  endtask

  task automatic wr_byte(input logic [7:0] b);
    @(negedge clk); wr = 1; wdata = b;
    @(negedge clk); wr = 0;
  endtask

  task automatic wait_empty();
    int k = 0;
    do begin @(negedge clk); k++; end while (empty !== 1'b1 && k < 5000);
  endtask

  task automatic wait_done();
    int k = 0;
    do begin @(negedge clk); k++; end while (done !== 1'b1 && k < 5000);
    repeat (2 * bitc) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: got %0d expected %0d", 1, 0);
    summary();
    $finish;
  end

  initial begin
    int base, n, viol, found;

    // R11 / R10 reset state
    repeat (3) @(negedge clk);
    chk(txd === 1 && txd_oe === 0, "R11 line released in reset", {txd, txd_oe}, 2);
    chk(empty === 1 && done === 1, "R11 flags set in reset", {empty, done}, 3);
    chk(irq_empty === 1 && irq_done === 1, "R10 requests follow flags", {irq_empty, irq_done}, 3);
    ie_empty = 0;
    @(negedge clk);
    chk(irq_empty === 0 && irq_done === 1, "R10 gated request", {irq_empty, irq_done}, 1);
    ie_done = 0;
    @(negedge clk);
    chk(irq_done === 0, "R10 gated complete request", irq_done, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);

    // R4 preamble timing, R3 done low while shifting
    base = rx_n;
    en = 1; wr = 1; wdata = 8'hA5;
    n = 0;
    do begin
      @(posedge clk); n++;
      @(negedge clk);
      if (n == 1) begin
        wr = 0;
        chk(done === 0, "R3 done low once preamble shifts", done, 0);
      end
    end while (txd !== 1'b0 && n < 300);
    chk(n == 10 * bitc + 1, "R4 start bit after one idle frame", n, 10 * bitc + 1);
    wait_done();
    chk(rx_n == base + 1 && rx[base] == 8'hA5, "R1 byte after preamble", rx[base], 8'hA5);
    // R8 idle enabled
    chk(txd === 1 && txd_oe === 1, "R8 mark driven while idle", {txd, txd_oe}, 3);
    chk(empty === 1 && done === 1, "R8 both flags set", {empty, done}, 3);

    // R1/R2 exhaustive byte sweep with double buffering
    base = rx_n;
    for (int b = 0; b < 256; b++) begin
      wait_empty();
      wr_byte(b[7:0]);
    end
    wait_done();
    chk(rx_n == base + 256, "R2 all swept frames sent", rx_n - base, 256);
    for (int b = 0; b < 256; b++)
      chk(rx[base + b] == b, "R1 sweep byte", rx[base + b], b);

    // R2 empty timing and overwrite of waiting byte
    base = rx_n;
    @(negedge clk); wr = 1; wdata = 8'h11;
    @(negedge clk); wr = 0;
    chk(empty === 0, "R2 empty cleared by write", empty, 0);
    @(negedge clk);
    chk(empty === 1, "R2 empty set on transfer", empty, 1);
    wr_byte(8'h22);
    chk(empty === 0, "R2 holding full", empty, 0);
    wr_byte(8'h33);
    wait_done();
    chk(rx_n == base + 2, "R2 overwrite frame count", rx_n - base, 2);
    chk(rx[base] == 8'h11 && rx[base + 1] == 8'h33, "R2 overwritten byte replaced", rx[base + 1], 8'h33);

    // R3 read-then-write clearing, R7 disabled writes discarded
    en = 0;
    repeat (3) @(negedge clk);
    wr_byte(8'h77);
    chk(done === 1, "R3 write without read keeps done", done, 1);
    chk(empty === 1, "R7 write discarded while disabled", empty, 1);
    @(negedge clk); rd = 1;
    @(negedge clk); rd = 0;
    wr_byte(8'h78);
    chk(done === 0, "R3 read then write clears done", done, 0);
    @(negedge clk); en = 1;
    @(negedge clk);
    chk(done === 0, "R3 done low during preamble", done, 0);
    wait_done();
    chk(done === 1, "R3 done set after preamble", done, 1);

    // R5 single-cycle break request, R6 mark afterwards
    base = rx_n;
    rclr();
    @(negedge clk); brk = 1;
    @(negedge clk); brk = 0;
    wait_done();
    chk(rl_n >= 2 && rl_lvl[1] == 0 && rl_len[1] == 10 * bitc, "R5 one break frame", rl_len[1], 10 * bitc);
    chk(rx_n == base + 1 && rx[base] == -1, "R5 break frame seen", rx[base], -1);
    chk(txd === 1 && done === 1, "R6 line at mark after break", {txd, done}, 3);

    // R5 held break outranks waiting byte, R6 one mark bit before data
    base = rx_n;
    rclr();
    @(negedge clk); brk = 1; wr = 1; wdata = 8'h55;
    @(negedge clk); wr = 0;
    repeat (14 * bitc) @(negedge clk);
    brk = 0;
    wait_done();
    chk(rl_n >= 3 && rl_lvl[1] == 0 && rl_len[1] == 20 * bitc, "R5 two break frames", rl_len[1], 20 * bitc);
    chk(rl_lvl[2] == 1 && rl_len[2] == bitc, "R6 single mark bit", rl_len[2], bitc);
    chk(rx_n == base + 2 && rx[base + 1] == 8'h55, "R5 data after break", rx[base + 1], 8'h55);

    // R5 break waits for the frame in progress
    base = rx_n;
    rclr();
    wr_byte(8'hFF);
    repeat (2 * bitc) @(negedge clk);
    brk = 1;
    @(negedge clk); brk = 0;
    wait_done();
    chk(rl_n >= 4 && rl_len[1] == bitc && rl_len[2] == 9 * bitc, "R5 data frame completes", rl_len[2], 9 * bitc);
    chk(rl_lvl[3] == 0 && rl_len[3] == 10 * bitc, "R5 break follows frame", rl_len[3], 10 * bitc);
    chk(rx_n == base + 2 && rx[base] == 8'hFF && rx[base + 1] == -1, "R5 frame order", rx[base], 8'hFF);

    // R4 enable edge while busy: idle frame after the current one
    base = rx_n;
    rclr();
    wr_byte(8'h3C);
    repeat (2 * bitc) @(negedge clk);
    en = 0;
    @(negedge clk); en = 1;
    wr_byte(8'h81);
    wait_done();
    found = 0;
    for (int i = 0; i < 64; i++)
      if (i < rl_n && rl_lvl[i] == 1 && rl_len[i] == 11 * bitc) found = 1;
    chk(found == 1, "R4 idle frame after busy frame", found, 1);
    chk(rx_n == base + 2 && rx[base + 1] == 8'h81, "R4 data after preamble", rx[base + 1], 8'h81);

    // R7 disable drains the frame and drops the waiting byte
    base = rx_n;
    wr_byte(8'h3C);
    wr_byte(8'hC3);
    chk(empty === 0, "R7 byte waiting", empty, 0);
    en = 0;
    @(negedge clk);
    chk(empty === 1, "R7 holding flushed", empty, 1);
    chk(txd_oe === 1, "R7 still driving while draining", txd_oe, 1);
    wait_done();
    chk(rx_n == base + 1 && rx[base] == 8'h3C, "R7 only current frame sent", rx_n - base, 1);
    chk(txd === 1 && txd_oe === 0, "R7 line released", {txd, txd_oe}, 2);

    // R9 open-drain drive
    od = 1;
    @(negedge clk); en = 1;
    wait_done();
    base = rx_n;
    viol = 0;
    @(negedge clk); wr = 1; wdata = 8'h0F;
    @(negedge clk); wr = 0;
    for (int i = 0; i < 12 * bitc; i++) begin
      if (txd_oe !== ~txd) viol++;
      @(negedge clk);
    end
    chk(viol == 0, "R9 drive only when low", viol, 0);
    wait_done();
    chk(txd_oe === 0 && txd === 1, "R9 released at mark", {txd, txd_oe}, 2);
    chk(rx_n == base + 1 && rx[base] == 8'h0F, "R9 frame decoded", rx[base], 8'h0F);
    od = 0;

    // R1 tick pacing: a tick every third cycle
    div = 3; bitc = 3 * TPB;
    repeat (4) @(negedge clk);
    base = rx_n;
    for (int b = 0; b < 16; b++) begin
      wait_empty();
      wr_byte(8'(b * 17 + 3));
    end
    wait_done();
    for (int b = 0; b < 16; b++)
      chk(rx[base + b] == ((b * 17 + 3) & 255), "R1 slow tick byte", rx[base + b], (b * 17 + 3) & 255);

    summary();
    $finish;
  end
endmodule